// File: doc/BRIEF.md
# Live-Value-Table Multi-Port RAM

This block is a synchronous memory with `NW` write ports and `NR` read ports, and every port can be used in every clock cycle. It is built only from plain arrays that have one write port and one read port. Each write port owns a bank of its own. Inside each bank there is one copy of the array for every read port, so all read ports can look up different addresses at the same time.

A narrow table held in flip-flops records, for each address, which write port stored its current value. On a read, that table entry chooses which bank's copy drives the read port. The separate banks therefore act as a single coherent memory, and no bank has to run faster than the system clock.

The table entries reset to write port 0. The arrays are not cleared by reset. The number of write ports, the number of read ports, the depth and the word width are all parameters. The design targets 1 to 8 write ports, 2 to 16 read ports and 2 to 256 entries.

Top module: `lvt_mp_ram`

## Requirements
- R1: A read address presented at a clock edge gives, just after that edge, the word most recently written to that address by any write port. Read latency is exactly one cycle.
- R2: Every read port looks up its own address in the same cycle, independently of the other read ports. Read port r returns its word on `rd_data[r*DW +: DW]`.
- R3: Write ports that are enabled in the same cycle with different addresses all take effect. Write port w uses `wr_en[w]`, `wr_addr[w*AW +: AW]` and `wr_data[w*DW +: DW]`.
- R4: When several enabled write ports hit the same address in one cycle, the highest-numbered of those ports decides both the stored word and the table entry.
- R5: A read of an address that is written in the same cycle returns the word from before that write. The new word becomes readable from the next read onward.
- R6: A write port whose enable is low changes neither the stored data nor the table, whatever its address and data inputs are.
- R7: Reset sets every table entry to write port 0 and does not touch the arrays. After reset, a read returns the word last written to that address through write port 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all ports are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the table and read selects |
| wr_en | input | NW | Write enable, one bit per write port |
| wr_addr | input | NW*AW | Write addresses, port w in bits [w*AW +: AW] |
| wr_data | input | NW*DW | Write data, port w in bits [w*DW +: DW] |
| rd_addr | input | NR*AW | Read addresses, port r in bits [r*AW +: AW] |
| rd_data | output | NR*DW | Read data one cycle after the address, port r in bits [r*DW +: DW] |

## Verification
Some behaviours are checked by assertions on every cycle:
- after a write, the next read of the same address returns the winning port's word;
- each table entry takes the index of the highest-numbered port that hit it;
- entries with no enabled write stay unchanged;
- the table is cleared after a reset cycle.

Other behaviours can only be shown by the bench scenarios:
- data returned by read-during-write;
- disabled ports carrying stray addresses and data;
- every read port reading different addresses in the same cycle;
- the fact that reset falls back to the data held in bank 0, because that depends on the array contents written long before.

// File: rtl/lvt_ram_pkg.sv
package lvt_ram_pkg;
  // Width of a write-port index; at least one bit so that every vector is legal.
  function automatic int sel_width(input int nw);
    return (nw > 1) ? $clog2(nw) : 1;
  endfunction
endpackage

// File: rtl/lvt_sdp_bank.sv
// One write port, one read port array. The read is registered and happens
// before the write, so a colliding read sees the earlier word.
module lvt_sdp_bank #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/lvt_live_table.sv
// Flip-flop table of last-writer indices, NW update ports, NR registered lookups.
module lvt_live_table #(
  parameter int NW    = 2,
  parameter int NR    = 4,
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int SW    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    wr_en,
  input  logic [NW*AW-1:0] wr_addr,
  input  logic [NR*AW-1:0] rd_addr,
  output logic [NR*SW-1:0] rd_sel
);
  logic [SW-1:0] tab_q [DEPTH];
  logic [SW-1:0] tab_d [DEPTH];
  logic [SW-1:0] sel_q [NR];
  logic [SW-1:0] sel_d [NR];

  // Next state: ascending port order, so the highest port is applied last.
  always_comb begin
    for (int k = 0; k < DEPTH; k++) tab_d[k] = tab_q[k];
    for (int w = 0; w < NW; w++) begin
      if (wr_en[w]) tab_d[wr_addr[w*AW +: AW]] = SW'(w);
    end
  end

  always_comb begin
    for (int r = 0; r < NR; r++) sel_d[r] = tab_q[rd_addr[r*AW +: AW]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) tab_q[k] <= '0;
      for (int r = 0; r < NR; r++) sel_q[r] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) tab_q[k] <= tab_d[k];
      for (int r = 0; r < NR; r++) sel_q[r] <= sel_d[r];
    end
  end

  genvar gr;
  generate
    for (gr = 0; gr < NR; gr++) begin : g_sel
      assign rd_sel[gr*SW +: SW] = sel_q[gr];
    end
  endgenerate

  // ---------------- checks ----------------
  logic [DEPTH-1:0] hit_vec;
  logic [NW-1:0]    outranked;

  always_comb begin
    hit_vec = '0;
    for (int k = 0; k < DEPTH; k++)
      for (int w = 0; w < NW; w++)
        if (wr_en[w] && (wr_addr[w*AW +: AW] == AW'(k))) hit_vec[k] = 1'b1;
  end

  always_comb begin
    outranked = '0;
    for (int w = 0; w < NW; w++)
      for (int v = 0; v < NW; v++)
        if (v > w && wr_en[v] && (wr_addr[v*AW +: AW] == wr_addr[w*AW +: AW]))
          outranked[w] = 1'b1;
  end

  genvar gk, gw;
  generate
    for (gk = 0; gk < DEPTH; gk++) begin : g_chk_entry
      // R6
      untouched_entry_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_vec[gk] |=> $stable(tab_q[gk]));
      // R7
      entry_cleared_by_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (tab_q[gk] == '0));
      for (gw = 0; gw < NW; gw++) begin : g_chk_win
        // R4
        top_port_owns_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_en[gw] && !outranked[gw] && (wr_addr[gw*AW +: AW] == AW'(gk)))
          |=> (tab_q[gk] == SW'(gw)));
      end
    end
  endgenerate
endmodule

// File: rtl/lvt_mp_ram.sv
module lvt_mp_ram
  import lvt_ram_pkg::*;
#(
  parameter int NW    = 2,
  parameter int NR    = 4,
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    wr_en,
  input  logic [NW*AW-1:0] wr_addr,
  input  logic [NW*DW-1:0] wr_data,
  input  logic [NR*AW-1:0] rd_addr,
  output logic [NR*DW-1:0] rd_data
);
  localparam int SW = sel_width(NW);

  logic [DW-1:0]    bank_q [NW][NR];
  logic [NR*SW-1:0] rd_sel;

  lvt_live_table #(
    .NW(NW), .NR(NR), .DEPTH(DEPTH), .AW(AW), .SW(SW)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .rd_sel  (rd_sel)
  );

  genvar gw, gr;
  generate
    for (gw = 0; gw < NW; gw++) begin : g_bank
      for (gr = 0; gr < NR; gr++) begin : g_copy
        lvt_sdp_bank #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_copy (
          .clk   (clk),
          .we    (wr_en[gw]),
          .waddr (wr_addr[gw*AW +: AW]),
          .wdata (wr_data[gw*DW +: DW]),
          .raddr (rd_addr[gr*AW +: AW]),
          .rdata (bank_q[gw][gr])
        );
      end
    end
  endgenerate

  // Output steering: registered select picks one bank copy per read port.
  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NR; r++)
      for (int w = 0; w < NW; w++)
        if (rd_sel[r*SW +: SW] == SW'(w)) rd_data[r*DW +: DW] = bank_q[w][r];
  end

  // ---------------- checks ----------------
  logic [1:0]    age_q;
  logic [1:0]    age_d;
  logic [NW-1:0] winner;

  always_comb age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      winner[w] = wr_en[w];
      for (int v = 0; v < NW; v++)
        if (v > w && wr_en[v] && (wr_addr[v*AW +: AW] == wr_addr[w*AW +: AW]))
          winner[w] = 1'b0;
    end
  end

  generate
    for (gw = 0; gw < NW; gw++) begin : g_chk_w
      for (gr = 0; gr < NR; gr++) begin : g_chk_r
        // R1 R4 R5
        read_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
          ((age_q == 2'd3) && $past(winner[gw]) &&
           (rd_addr[gr*AW +: AW] == $past(wr_addr[gw*AW +: AW])))
          |=> (rd_data[gr*DW +: DW] == $past(wr_data[gw*DW +: DW], 2)));
      end
    end
  endgenerate
endmodule

// File: tb/lvt_mp_ram_test.sv
module lvt_mp_ram_test;
  localparam int NW = 2, NR = 4, DEPTH = 16, DW = 8, AW = 4;
  localparam int NV = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NW-1:0]    wr_en;
  logic [NW*AW-1:0] wr_addr;
  logic [NW*DW-1:0] wr_data;
  logic [NR*AW-1:0] rd_addr;
  logic [NR*DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  lvt_mp_ram #(.NW(NW), .NR(NR), .DEPTH(DEPTH), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Row: {wr_en, wa1, wa0, wd1, wd0, ra3, ra2, ra1, ra0, e3, e2, e1, e0, lane check mask}
  localparam logic [77:0] VEC [NV] = '{
    {2'b01, 4'h0, 4'h1, 8'h00, 8'h11, 16'h0000, 32'h00000000, 4'b0000},
    {2'b10, 4'h2, 4'h0, 8'h22, 8'h00, 16'h0001, 32'h00000011, 4'b0001},
    {2'b11, 4'h4, 4'h3, 8'h44, 8'h33, 16'h0012, 32'h00001122, 4'b0011},
    {2'b00, 4'h0, 4'h0, 8'h00, 8'h00, 16'h1243, 32'h11224433, 4'b1111},
    {2'b11, 4'h5, 4'h5, 8'h51, 8'h50, 16'h0000, 32'h00000000, 4'b0000},
    {2'b00, 4'h0, 4'h0, 8'h00, 8'h00, 16'h5555, 32'h51515151, 4'b1111},
    {2'b01, 4'h0, 4'h5, 8'h00, 8'h60, 16'h0005, 32'h00000051, 4'b0001},
    {2'b00, 4'h0, 4'h0, 8'h00, 8'h00, 16'h0015, 32'h00001160, 4'b0011},
    {2'b00, 4'h2, 4'h1, 8'hEE, 8'hFF, 16'h0000, 32'h00000000, 4'b0000},
    {2'b00, 4'h0, 4'h0, 8'h00, 8'h00, 16'h0021, 32'h00002211, 4'b0011}
  };

  function automatic string row_tag(input int i);
    case (i)
      1:       return "R1";
      2:       return "R2";
      3:       return "R3";
      5:       return "R4";
      6, 7:    return "R5";
      9:       return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int lane, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s lane %0d: actual %h expected %h", req, lane, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = '0; wr_addr = '0; wr_data = '0; rd_addr = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // Vector table walk.
    for (int i = 0; i < NV; i++) begin
      wr_en   = VEC[i][77:76];
      wr_addr = VEC[i][75:68];
      wr_data = VEC[i][67:52];
      rd_addr = VEC[i][51:36];
      step();
      for (int r = 0; r < NR; r++)
        if (VEC[i][r])
          check(row_tag(i), r, rd_data[r*DW +: DW], VEC[i][4 + r*DW +: DW]);
    end
    idle_inputs();

    // Full sweep: port 0 ascends, port 1 descends; the later write wins (R1, R2).
    for (int i = 0; i < DEPTH; i++) begin
      wr_en = 2'b11;
      wr_addr = {4'(DEPTH - 1 - i), 4'(i)};
      wr_data = {8'(8'h80 + (DEPTH - 1 - i)), 8'(i * 3 + 1)};
      step();
    end
    idle_inputs();
    for (int j = 0; j < DEPTH; j++) begin
      for (int r = 0; r < NR; r++) rd_addr[r*AW +: AW] = 4'((j + r * 4) % DEPTH);
      step();
      for (int r = 0; r < NR; r++) begin
        int a;
        a = (j + r * 4) % DEPTH;
        check("R2", r, rd_data[r*DW +: DW], (a >= 8) ? 8'(a * 3 + 1) : 8'(8'h80 + a));
      end
    end

    // Reset falls back to bank 0 contents (R7).
    idle_inputs();
    wr_en = 2'b01; wr_addr = {4'h0, 4'h7}; wr_data = {8'h00, 8'h70};
    step();
    wr_en = 2'b10; wr_addr = {4'h7, 4'h0}; wr_data = {8'h71, 8'h00};
    step();
    idle_inputs();
    rd_addr = 16'h0007;
    step();
    check("R1", 0, rd_data[7:0], 8'h71);
    rst_n = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    rd_addr = {4'h0, 4'hC, 4'h3, 4'h7};
    step();
    check("R7", 0, rd_data[7:0],   8'h70);
    check("R7", 1, rd_data[15:8],  8'h0A);
    check("R7", 2, rd_data[23:16], 8'h25);

    finish_run();
  end
endmodule